// File: doc/BRIEF.md
# Trimmable Cycle and Retired-Instruction Counters

This unit keeps two free-running event counters for a processor core: one that advances on every clock and one that advances on each retire pulse from the pipeline. A parameter sets how many bits of each counter are built, from 0 to 64. Only the 64-bit build is fully compliant. Narrower builds save flops and adder depth.

The unit answers CSR reads through two views. The user view at bank 0xC is read-only. The machine view at bank 0xB is writable. Each view has a low word and a high word for each counter. The surrounding CSR logic presents an address, a read strobe and a write strobe. The unit returns read data in the same cycle and raises an illegal-access indication when the addressed high word is not built in the chosen width.

Two constant flags report the configuration, so software can learn whether the counters are shortened or absent.

Top module: `retire_counters`

## Requirements
- R1: After reset both counters are zero. The cycle counter then rises by one on every rising clock edge on which no write hits it.
- R2: The retired-instruction counter rises by one on each rising clock edge where `retirePulse` is high, and holds otherwise.
- R3: Read addresses are decoded as follows. Offset bit 1 selects the counter (0 = cycle, 1 = retired). Offset bit 7 selects the word (0 = bits 31:0, 1 = bits 63:32). So 0xC00/0xB00 is the cycle low word, 0xC02/0xB02 the retired low word, 0xC80/0xB80 the cycle high word and 0xC82/0xB82 the retired high word, and both banks return the same value. Read data is zero when `csrRe` is low or the address is none of these eight.
- R4: A write with `csrWe` to 0xB00 or 0xB02 replaces bits 31:0 of that counter on the next edge and keeps the other bits. Any increment due in that cycle is dropped.
- R5: A write to 0xB80 or 0xB82 replaces bits 63:32 of that counter on the next edge. Any increment due in that cycle is dropped.
- R6: Writes to user-view addresses (bank 0xC) change no counter.
- R7: Counting wraps within the built width: a counter holding all ones reads zero after its next increment.
- R8: For widths 32 to 63, high-word bits at and above the width read zero, and written values do not stick there.
- R9: For widths 1 to 31, any read or write of a high-word address raises `illegalAcc` in that cycle, the high word reads zero, and low-word bits at and above the width read zero.
- R10: For width 0, every counter word reads zero, writes have no effect, and high-word accesses raise `illegalAcc`.
- R11: `cfgShortCnt` is 1 for widths 1 to 63. `cfgNoCnt` is 1 only for width 0. Both are 0 at width 64.
- R12: `illegalAcc` is never raised without an access, and never for widths of 32 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrAddr | input | 12 | CSR address of the current access |
| csrRe | input | 1 | Read access this cycle |
| csrWe | input | 1 | Write access this cycle |
| csrWdata | input | 32 | Write data |
| retirePulse | input | 1 | One instruction retired this cycle |
| csrRdata | output | 32 | Read data, combinational from address |
| illegalAcc | output | 1 | Access to a high word that is not built |
| cfgShortCnt | output | 1 | Counters are narrower than 64 bits but present |
| cfgNoCnt | output | 1 | Counters are not built |

## Verification
The bench drives the same stimulus into four builds at once (64, 40, 16 and 0 bits), so each width range is compared against its own expected value. It checks several things:
- A write that lands in a counting cycle must win. A design that added the increment on top would read back one higher than written.
- Values written to the upper word of a 40-bit build must be cut at bit 39. A design that kept the extra bits, or raised an illegal access, would be caught.
- The 16-bit and empty builds must flag high-word accesses and mask their low words.
- Counters forced to all ones must wrap to zero across both words. A carry that leaked or stopped at bit 31 would show up in the following reads.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [3:0] BANK_USER = 4'hC;
  localparam logic [3:0] BANK_MACH = 4'hB;
  localparam int NUM_CNT = 2;
  localparam int CNT_IDX_CYC = 0;

  typedef struct packed {
    logic [NUM_CNT-1:0] wrLo;
    logic [NUM_CNT-1:0] wrHi;
    logic               rdHit;
    logic               rdIdx;
    logic               rdHi;
  } ctlStrb_t;
endpackage

// File: rtl/rc_ctl.sv
module rc_ctl
  import rc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic [11:0] csrAddr,
  input  logic        csrRe,
  input  logic        csrWe,
  output ctlStrb_t    strb,
  output logic        illegalAcc
);
  localparam bit HAS_HI = (CNT_W >= 32);

  logic isUser, isMach, offHit, hiWord, cntSel, addrHit;

  assign isUser  = (csrAddr[11:8] == BANK_USER);
  assign isMach  = (csrAddr[11:8] == BANK_MACH);
  assign offHit  = csrAddr[7:0] inside {8'h00, 8'h02, 8'h80, 8'h82};
  assign hiWord  = csrAddr[7];
  assign cntSel  = csrAddr[1];
  assign addrHit = (isUser || isMach) && offHit;

  always_comb begin
    strb       = '0;
    strb.rdIdx = cntSel;
    strb.rdHi  = hiWord;
    strb.rdHit = csrRe && addrHit && (!hiWord || HAS_HI);
    if (csrWe && isMach && offHit) begin
      if (!hiWord) strb.wrLo[cntSel] = 1'b1;
      else if (HAS_HI) strb.wrHi[cntSel] = 1'b1;
    end
  end

  assign illegalAcc = (csrRe || csrWe) && addrHit && hiWord && !HAS_HI;
endmodule

// File: rtl/rc_dp.sv
module rc_dp
  import rc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        retirePulse,
  input  ctlStrb_t    strb,
  input  logic [31:0] csrWdata,
  output logic [31:0] csrRdata
);
  localparam int STORE_W = (CNT_W == 0) ? 1 : CNT_W;

  logic [63:0] extVal [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    if (CNT_W == 0) begin : g_none
      assign extVal[g] = '0;
    end else begin : g_impl
      logic               incEn;
      logic [STORE_W-1:0] cntQ;
      logic [63:0]        curExt;
      logic [63:0]        mergedVal;

      assign incEn  = (g == CNT_IDX_CYC) ? 1'b1 : retirePulse;
      assign curExt = 64'(cntQ);

      always_comb begin
        mergedVal = curExt;
        if (strb.wrLo[g]) mergedVal[31:0]  = csrWdata;
        if (strb.wrHi[g]) mergedVal[63:32] = csrWdata;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cntQ <= '0;
        else if (strb.wrLo[g] || strb.wrHi[g]) cntQ <= mergedVal[STORE_W-1:0];
        else if (incEn) cntQ <= cntQ + STORE_W'(1);
      end

      assign extVal[g] = curExt;
    end
  end

  logic [63:0] selVal;
  assign selVal = extVal[strb.rdIdx];

  always_comb begin
    if (!strb.rdHit) csrRdata = '0;
    else if (strb.rdHi) csrRdata = selVal[63:32];
    else csrRdata = selVal[31:0];
  end
endmodule

// File: rtl/retire_counters.sv
module retire_counters
  import rc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] csrAddr,
  input  logic        csrRe,
  input  logic        csrWe,
  input  logic [31:0] csrWdata,
  input  logic        retirePulse,
  output logic [31:0] csrRdata,
  output logic        illegalAcc,
  output logic        cfgShortCnt,
  output logic        cfgNoCnt
);
  localparam bit IS_SHORT = (CNT_W > 0) && (CNT_W < 64);
  localparam bit IS_NONE  = (CNT_W == 0);

  ctlStrb_t strb;

  rc_ctl #(.CNT_W(CNT_W)) ctl_i (
    .csrAddr   (csrAddr),
    .csrRe     (csrRe),
    .csrWe     (csrWe),
    .strb      (strb),
    .illegalAcc(illegalAcc)
  );

  rc_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .retirePulse(retirePulse),
    .strb       (strb),
    .csrWdata   (csrWdata),
    .csrRdata   (csrRdata)
  );

  assign cfgShortCnt = IS_SHORT;
  assign cfgNoCnt    = IS_NONE;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int CNT_W = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] csrAddr,
  input logic        csrRe,
  input logic        csrWe,
  input logic        retirePulse,
  input logic [31:0] csrRdata,
  input logic        illegalAcc,
  input logic [1:0]  wrLo,
  input logic [1:0]  wrHi
);
  localparam logic [31:0] LOW_MASK = (CNT_W >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << CNT_W) - 64'd1);

  logic rdCycLo, rdInsLo;
  assign rdCycLo = csrRe && !csrWe && (csrAddr == 12'hC00);
  assign rdInsLo = csrRe && !csrWe && (csrAddr == 12'hC02);

  // R1: an undisturbed cycle counter steps by one per edge
  p_cycle_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdCycLo ##1 rdCycLo |-> csrRdata == ((($past(csrRdata)) + 32'd1) & LOW_MASK));

  // R2: retired counter follows the retire pulse
  p_retire_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdInsLo ##1 rdInsLo |-> csrRdata == ((($past(csrRdata)) + {31'd0, $past(retirePulse)}) & LOW_MASK));

  // R4: at most one counter word written per cycle
  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrLo, wrHi}));

  // R6: user bank never produces a write strobe
  p_user_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr[11:8] == 4'hC) |-> (wrLo == 2'b00 && wrHi == 2'b00));

  // R12: illegal only with an access to a high word
  p_illegal_access_r12: assert property (@(posedge clk) disable iff (!rstN)
    illegalAcc |-> ((csrRe || csrWe) && csrAddr[7]));

  if (CNT_W >= 32) begin : g_wide
    // R12: wide builds never flag
    p_wide_legal_r12: assert property (@(posedge clk) disable iff (!rstN) !illegalAcc);
  end

  if (CNT_W == 0) begin : g_empty
    // R10: empty build always reads zero
    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rstN) csrRdata == 32'd0);
  end
endmodule

bind retire_counters rc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .csrAddr    (csrAddr),
  .csrRe      (csrRe),
  .csrWe      (csrWe),
  .retirePulse(retirePulse),
  .csrRdata   (csrRdata),
  .illegalAcc (illegalAcc),
  .wrLo       (strb.wrLo),
  .wrHi       (strb.wrHi)
);

// File: tb/retire_counters_tb_top.sv
module retire_counters_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = 12'hC00;
  logic        csrRe = 1'b1;
  logic        csrWe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic        retirePulse = 1'b0;

  logic [31:0] rd64, rd40, rd16, rd0;
  logic        il64, il40, il16, il0;
  logic        sh64, sh40, sh16, sh0, no64, no40, no16, no0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retire_counters #(.CNT_W(64)) dut_i (.clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRe(csrRe),
    .csrWe(csrWe), .csrWdata(csrWdata), .retirePulse(retirePulse), .csrRdata(rd64),
    .illegalAcc(il64), .cfgShortCnt(sh64), .cfgNoCnt(no64));
  retire_counters #(.CNT_W(40)) dut40_i (.clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRe(csrRe),
    .csrWe(csrWe), .csrWdata(csrWdata), .retirePulse(retirePulse), .csrRdata(rd40),
    .illegalAcc(il40), .cfgShortCnt(sh40), .cfgNoCnt(no40));
  retire_counters #(.CNT_W(16)) dut16_i (.clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRe(csrRe),
    .csrWe(csrWe), .csrWdata(csrWdata), .retirePulse(retirePulse), .csrRdata(rd16),
    .illegalAcc(il16), .cfgShortCnt(sh16), .cfgNoCnt(no16));
  retire_counters #(.CNT_W(0)) dut0_i (.clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRe(csrRe),
    .csrWe(csrWe), .csrWdata(csrWdata), .retirePulse(retirePulse), .csrRdata(rd0),
    .illegalAcc(il0), .cfgShortCnt(sh0), .cfgNoCnt(no0));

  typedef struct packed {
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] e64;
    logic [31:0] e40;
    logic [31:0] e16;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{12'hB00, 32'h1234_5678, 12'hC00, 32'h1234_5678, 32'h1234_5678, 32'h0000_5678}, // R4 R3
    '{12'hB80, 32'hCAFE_0001, 12'hC80, 32'hCAFE_0001, 32'h0000_0001, 32'h0000_0000}, // R5 R8
    '{12'hB02, 32'h0000_0010, 12'hB02, 32'h0000_0010, 32'h0000_0010, 32'h0000_0010}, // R4
    '{12'hB82, 32'h0000_0007, 12'hC82, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000}, // R5
    '{12'hC02, 32'h0000_DEAD, 12'hC02, 32'h0000_0010, 32'h0000_0010, 32'h0000_0010}, // R6
    '{12'hC82, 32'h0000_BEEF, 12'hB82, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000}, // R6
    '{12'h123, 32'h0000_0005, 12'h123, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R3
    '{12'hB00, 32'h0000_0000, 12'hB80, 32'hCAFE_0001, 32'h0000_0001, 32'h0000_0000}  // R4
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic bit isHighAddr(input logic [11:0] a);
    return (a[11:8] == 4'hB || a[11:8] == 4'hC) && (a[7:0] == 8'h80 || a[7:0] == 8'h82);
  endfunction

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrRe = 1'b0; csrAddr = a; csrWdata = d;
    #1;
    chk("R9", "illegal w16", {31'd0, il16}, {31'd0, isHighAddr(a)});
    chk("R10", "illegal w0", {31'd0, il0}, {31'd0, isHighAddr(a)});
    chk("R12", "illegal w64/w40", {30'd0, il64, il40}, 32'd0);
    @(posedge clk);
  endtask

  task automatic readAt(input logic [11:0] a);
    @(negedge clk);
    csrWe = 1'b0; csrRe = 1'b1; csrAddr = a;
    #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // reset state R1 R10 R11
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset cycle w64", rd64, 32'd0);
    chk("R1", "reset cycle w16", rd16, 32'd0);
    csrAddr = 12'hC02; #1;
    chk("R1", "reset instret w40", rd40, 32'd0);
    chk("R11", "flags w64", {30'd0, sh64, no64}, 32'd0);
    chk("R11", "flags w40", {30'd0, sh40, no40}, 32'd2);
    chk("R11", "flags w16", {30'd0, sh16, no16}, 32'd2);
    chk("R11", "flags w0", {30'd0, sh0, no0}, 32'd1);
    @(negedge clk); rstN = 1'b1;

    // table walk: write then read back one edge later
    for (int i = 0; i < 8; i++) begin
      doWrite(VECS[i].wa, VECS[i].wd);
      readAt(VECS[i].ra);
      chk("R3", $sformatf("vec%0d w64", i), rd64, VECS[i].e64);
      chk("R8", $sformatf("vec%0d w40", i), rd40, VECS[i].e40);
      chk("R9", $sformatf("vec%0d w16", i), rd16, VECS[i].e16);
      chk("R10", $sformatf("vec%0d w0", i), rd0, 32'd0);
      chk("R9", $sformatf("vec%0d illegal w16", i), {31'd0, il16}, {31'd0, isHighAddr(VECS[i].ra)});
      chk("R10", $sformatf("vec%0d illegal w0", i), {31'd0, il0}, {31'd0, isHighAddr(VECS[i].ra)});
      chk("R12", $sformatf("vec%0d illegal wide", i), {30'd0, il64, il40}, 32'd0);
    end

    // R1: free running cycle counter
    doWrite(12'hB00, 32'd100);
    readAt(12'hC00);
    chk("R1", "cycle t0 w64", rd64, 32'd100);
    chk("R1", "cycle t0 w16", rd16, 32'd100);
    @(negedge clk); #1;
    chk("R1", "cycle t1 w64", rd64, 32'd101);
    @(negedge clk); #1;
    chk("R1", "cycle t2 w40", rd40, 32'd102);
    chk("R1", "cycle t2 w16", rd16, 32'd102);

    // R2: retire pulses
    doWrite(12'hB02, 32'd0);
    @(negedge clk);
    csrWe = 1'b0; csrRe = 1'b1; csrAddr = 12'hC02; retirePulse = 1'b1;
    repeat (3) @(negedge clk);
    retirePulse = 1'b0;
    @(negedge clk); #1;
    chk("R2", "retired w64", rd64, 32'd3);
    chk("R2", "retired w16", rd16, 32'd3);
    chk("R10", "retired w0", rd0, 32'd0);

    // R4: write beats a same-cycle retire
    @(negedge clk);
    csrWe = 1'b1; csrRe = 1'b0; csrAddr = 12'hB02; csrWdata = 32'd50; retirePulse = 1'b1;
    @(negedge clk);
    csrWe = 1'b0; csrRe = 1'b1; csrAddr = 12'hC02; retirePulse = 1'b0;
    #1;
    chk("R4", "write over retire w64", rd64, 32'd50);
    chk("R4", "write over retire w40", rd40, 32'd50);

    // R7 R8: wrap across both words
    doWrite(12'hB80, 32'hFFFF_FFFF);
    readAt(12'hC80);
    chk("R5", "high all ones w64", rd64, 32'hFFFF_FFFF);
    chk("R8", "high trimmed w40", rd40, 32'h0000_00FF);
    chk("R9", "high absent w16", rd16, 32'd0);
    doWrite(12'hB00, 32'hFFFF_FFFF);
    readAt(12'hC00);
    chk("R7", "low all ones w64", rd64, 32'hFFFF_FFFF);
    chk("R9", "low trimmed w16", rd16, 32'h0000_FFFF);
    readAt(12'hC80);
    chk("R7", "wrapped high w64", rd64, 32'd0);
    chk("R7", "wrapped high w40", rd40, 32'd0);
    readAt(12'hC00);
    chk("R7", "wrapped low w16", rd16, 32'd1);
    chk("R7", "wrapped low w64", rd64, 32'd1);

    // R3: read strobe low gives zero
    @(negedge clk);
    csrRe = 1'b0; csrAddr = 12'hB02; #1;
    chk("R3", "no read strobe", rd64, 32'd0);
    chk("R12", "no access no illegal", {31'd0, il16}, 32'd0);

    summary();
  end
endmodule